// File: doc/BRIEF.md
# Handshaked Parallel Port Interface

This block sits as a slave on a 32-bit processor bus with no shared timing between master and slave. Each transfer is fully interlocked. The master sets up the address, the direction and any write data. It then raises its request line (`bus_mrdy`). The block decodes the address, carries out the access and raises its acknowledge (`bus_srdy`). The acknowledge stays high until the master withdraws its request. Read data is valid for as long as the acknowledge is high.

Behind the bus the block serves two byte-wide device ports. The first is an input port: a device presents a byte with a one-cycle valid strobe, and the processor collects it. The second is an output port: the processor deposits a byte, and a device takes it and acknowledges. Each port has a data word and a status word at adjacent word addresses. Address bit 2 selects the status word. Each status word carries a single flag, and every other bit reads as zero. The processor can therefore poll for a waiting input byte, or for an output register that is free to accept the next byte.

Top module: `hs_pport`

## Requirements
- R1: After reset, `bus_srdy` is 0 and `bus_rdata` is 0. The input flag is clear, so input status reads 0. The output flag is set, so output status reads 4. `out_dev_data` is 0 and `out_dev_avail` is 0.
- R2: If `bus_mrdy` is sampled high with an address inside the input window (IN_BASE, 8 bytes) or the output window (OUT_BASE, 8 bytes), `bus_srdy` rises at the next clock edge. If the address is outside both windows, `bus_srdy` stays 0 however long `bus_mrdy` is held.
- R3: `bus_srdy` stays high while `bus_mrdy` stays high. It falls at the first edge at which `bus_mrdy` is sampled low. `bus_rdata` holds steady while `bus_srdy` is high and is 0 while `bus_srdy` is low. A write returns 0 on `bus_rdata`.
- R4: A read with address bit 2 = 0 in the input window returns the held input byte in bits 7:0, with zeros above. A read with bit 2 = 1 returns the input-ready flag in bit 1, with zeros in all other bits.
- R5: A pulse on `in_dev_stb` captures `in_dev_data` and sets the input-ready flag. A later pulse overwrites the held byte. A read of the input data word clears the flag. If a strobe arrives in the same cycle as that read, the strobe wins: the flag stays set and the new byte is held.
- R6: A write with bit 2 = 0 in the output window loads `bus_wdata[7:0]` onto `out_dev_data` and clears the output-free flag, so `out_dev_avail` goes to 1. A read with bit 2 = 1 returns the output-free flag in bit 2, with zeros in all other bits. A read with bit 2 = 0 returns the held output byte.
- R7: `out_dev_ack` sets the output-free flag. If the ack arrives in the same cycle as a data write, the write wins and the flag stays clear. An ack while the flag is already set changes nothing.
- R8: A write to either input word, or to the output status word, is acknowledged but changes no flag and no held byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | ADDR_W | Byte address from the master |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 32 | Write data |
| bus_mrdy | input | 1 | Master request, held until acknowledged |
| bus_srdy | output | 1 | Slave acknowledge |
| bus_rdata | output | 32 | Read data, valid while bus_srdy is high |
| in_dev_data | input | 8 | Byte from the input device |
| in_dev_stb | input | 1 | One-cycle valid strobe for in_dev_data |
| out_dev_data | output | 8 | Byte presented to the output device |
| out_dev_ack | input | 1 | Output device has taken the byte |
| out_dev_avail | output | 1 | A byte is waiting for the output device |

## Verification
The hard cases are the collisions between a device event and the processor access that reaches the same flag in the same clock. One is a strobe landing on the edge where the input data read is carried out. The other is an ack landing on the edge of an output data write. The bench can raise the device line in the same half-cycle as `bus_mrdy`, so both land on the edge that carries out the access. The bench then reads status and data back through the bus to see which event won. Around these cases, the bench sweeps all 256 byte values through both ports with a full handshake each time.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
    localparam int WORD_W   = 32;
    localparam int BYTE_W   = 8;
    localparam int KIN_POS  = 1;
    localparam int DOUT_POS = 2;

    typedef enum logic {
        HS_IDLE,
        HS_HOLD
    } hs_state_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_IN_DATA,
        SEL_IN_STAT,
        SEL_OUT_DATA,
        SEL_OUT_STAT
    } reg_sel_e;
endpackage

// File: rtl/hsp_decode.sv
module hsp_decode
    import hsp_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] IN_BASE  = 16'h0010,
    parameter logic [ADDR_W-1:0] OUT_BASE = 16'h0020
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam int WIN_LSB = 3;

    logic hit_in, hit_out;

    always_comb begin
        hit_in  = (addr[ADDR_W-1:WIN_LSB] == IN_BASE[ADDR_W-1:WIN_LSB]);
        hit_out = (addr[ADDR_W-1:WIN_LSB] == OUT_BASE[ADDR_W-1:WIN_LSB]);
        sel     = SEL_NONE;
        if (hit_in)
            sel = addr[2] ? SEL_IN_STAT : SEL_IN_DATA;
        else if (hit_out)
            sel = addr[2] ? SEL_OUT_STAT : SEL_OUT_DATA;
    end
endmodule

// File: rtl/hsp_handshake.sv
module hsp_handshake
    import hsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrdy,
    input  logic              selected,
    input  logic              is_write,
    input  logic [WORD_W-1:0] rd_word,
    output logic              srdy,
    output logic [WORD_W-1:0] rdata,
    output logic              fire
);
    typedef struct packed {
        hs_state_e         state;
        logic              srdy;
        logic [WORD_W-1:0] rdata;
    } hs_regs_t;

    hs_regs_t r_d, r_q;

    always_comb begin
        r_d  = r_q;
        fire = 1'b0;
        case (r_q.state)
            HS_IDLE: begin
                if (mrdy && selected) begin
                    fire       = 1'b1;
                    r_d.state  = HS_HOLD;
                    r_d.srdy   = 1'b1;
                    r_d.rdata  = is_write ? '0 : rd_word;
                end
            end
            HS_HOLD: begin
                if (!mrdy) begin
                    r_d.state = HS_IDLE;
                    r_d.srdy  = 1'b0;
                    r_d.rdata = '0;
                end
            end
            default: r_d = '{state: HS_IDLE, srdy: 1'b0, rdata: '0};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: HS_IDLE, srdy: 1'b0, rdata: '0};
        else        r_q <= r_d;
    end

    assign srdy  = r_q.srdy;
    assign rdata = r_q.rdata;

    // R2
    srdy_rise_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(srdy) |-> $past(mrdy));
    // R3
    srdy_fall_needs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(srdy) |-> !$past(mrdy));
    // R3
    rdata_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (srdy && $past(srdy)) |-> $stable(rdata));
    // R3
    rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !srdy |-> (rdata == '0));
endmodule

// File: rtl/hsp_in_port.sv
module hsp_in_port
    import hsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] dev_data,
    input  logic              dev_stb,
    input  logic              rd_take,
    output logic [BYTE_W-1:0] held,
    output logic              ready
);
    typedef struct packed {
        logic [BYTE_W-1:0] held;
        logic              ready;
    } in_regs_t;

    in_regs_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (rd_take)
            p_d.ready = 1'b0;
        if (dev_stb) begin
            p_d.held  = dev_data;
            p_d.ready = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign held  = p_q.held;
    assign ready = p_q.ready;

    // R5
    ready_set_by_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(dev_stb));
    // R5
    ready_clear_by_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> ($past(rd_take) && !$past(dev_stb)));
endmodule

// File: rtl/hsp_out_port.sv
module hsp_out_port
    import hsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              wr_load,
    input  logic              dev_ack,
    output logic [BYTE_W-1:0] dev_data,
    output logic              free
);
    typedef struct packed {
        logic [BYTE_W-1:0] held;
        logic              free;
    } out_regs_t;

    out_regs_t o_d, o_q;

    always_comb begin
        o_d = o_q;
        if (dev_ack)
            o_d.free = 1'b1;
        if (wr_load) begin
            o_d.held = wr_byte;
            o_d.free = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '{held: '0, free: 1'b1};
        else        o_q <= o_d;
    end

    assign dev_data = o_q.held;
    assign free     = o_q.free;

    // R6
    free_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(free) |-> $past(wr_load));
    // R7
    free_set_by_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(free) |-> ($past(dev_ack) && !$past(wr_load)));
    // R8
    byte_moves_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dev_data) |-> $past(wr_load));
endmodule

// File: rtl/hs_pport.sv
module hs_pport
    import hsp_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] IN_BASE  = 16'h0010,
    parameter logic [ADDR_W-1:0] OUT_BASE = 16'h0020
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_write,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_mrdy,
    output logic              bus_srdy,
    output logic [31:0]       bus_rdata,
    input  logic [7:0]        in_dev_data,
    input  logic              in_dev_stb,
    output logic [7:0]        out_dev_data,
    input  logic              out_dev_ack,
    output logic              out_dev_avail
);
    reg_sel_e          sel;
    logic              fire;
    logic [WORD_W-1:0] rd_word;
    logic [BYTE_W-1:0] in_held;
    logic              in_ready;
    logic              out_free;
    logic              in_take;
    logic              out_load;

    hsp_decode #(.ADDR_W(ADDR_W), .IN_BASE(IN_BASE), .OUT_BASE(OUT_BASE)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    always_comb begin
        rd_word = '0;
        case (sel)
            SEL_IN_DATA:  rd_word[BYTE_W-1:0] = in_held;
            SEL_IN_STAT:  rd_word[KIN_POS]     = in_ready;
            SEL_OUT_DATA: rd_word[BYTE_W-1:0] = out_dev_data;
            SEL_OUT_STAT: rd_word[DOUT_POS]    = out_free;
            default:      rd_word = '0;
        endcase
        in_take  = fire && !bus_write && (sel == SEL_IN_DATA);
        out_load = fire &&  bus_write && (sel == SEL_OUT_DATA);
    end

    hsp_handshake u_hs (
        .clk      (clk),
        .rst_n    (rst_n),
        .mrdy     (bus_mrdy),
        .selected (sel != SEL_NONE),
        .is_write (bus_write),
        .rd_word  (rd_word),
        .srdy     (bus_srdy),
        .rdata    (bus_rdata),
        .fire     (fire)
    );

    hsp_in_port u_in (
        .clk      (clk),
        .rst_n    (rst_n),
        .dev_data (in_dev_data),
        .dev_stb  (in_dev_stb),
        .rd_take  (in_take),
        .held     (in_held),
        .ready    (in_ready)
    );

    hsp_out_port u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_byte  (bus_wdata[BYTE_W-1:0]),
        .wr_load  (out_load),
        .dev_ack  (out_dev_ack),
        .dev_data (out_dev_data),
        .free     (out_free)
    );

    assign out_dev_avail = !out_free;

    // R2
    no_ack_unselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_srdy) |-> ($past(sel) != SEL_NONE));
endmodule

// File: tb/test_hs_pport.sv
module test_hs_pport;
    localparam int AW = 16;
    localparam logic [AW-1:0] IN_A  = 16'h0010;
    localparam logic [AW-1:0] OUT_A = 16'h0020;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_write = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_mrdy = 1'b0;
    logic          bus_srdy;
    logic [31:0]   bus_rdata;
    logic [7:0]    in_dev_data = '0;
    logic          in_dev_stb = 1'b0;
    logic [7:0]    out_dev_data;
    logic          out_dev_ack = 1'b0;
    logic          out_dev_avail;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] rd;

    always #4 clk = ~clk;

    hs_pport #(.ADDR_W(AW), .IN_BASE(IN_A), .OUT_BASE(OUT_A)) i_hs_pport (
        .clk, .rst_n, .bus_addr, .bus_write, .bus_wdata, .bus_mrdy,
        .bus_srdy, .bus_rdata, .in_dev_data, .in_dev_stb,
        .out_dev_data, .out_dev_ack, .out_dev_avail
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [AW-1:0] a, input logic w, input logic [31:0] wd,
                        input logic with_stb, input logic with_ack, output logic [31:0] rdo);
        @(negedge clk);
        bus_addr = a; bus_write = w; bus_wdata = wd; bus_mrdy = 1'b1;
        if (with_stb) in_dev_stb = 1'b1;
        if (with_ack) out_dev_ack = 1'b1;
        @(negedge clk);
        in_dev_stb = 1'b0; out_dev_ack = 1'b0;
        chk("R2 srdy after request", {31'b0, bus_srdy}, 32'd1);
        rdo = bus_rdata;
        if (w) chk("R3 write rdata", bus_rdata, 32'd0);
        @(negedge clk);
        chk("R3 srdy held", {31'b0, bus_srdy}, 32'd1);
        chk("R3 rdata steady", bus_rdata, rdo);
        bus_mrdy = 1'b0;
        @(negedge clk);
        chk("R3 srdy released", {31'b0, bus_srdy}, 32'd0);
        chk("R3 rdata idle", bus_rdata, 32'd0);
    endtask

    task automatic strobe(input logic [7:0] b);
        @(negedge clk); in_dev_data = b; in_dev_stb = 1'b1;
        @(negedge clk); in_dev_stb = 1'b0;
    endtask

    task automatic ack_pulse();
        @(negedge clk); out_dev_ack = 1'b1;
        @(negedge clk); out_dev_ack = 1'b0;
    endtask

    task automatic unselected(input logic [AW-1:0] a);
        @(negedge clk); bus_addr = a; bus_write = 1'b0; bus_mrdy = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R2 no srdy outside windows", {31'b0, bus_srdy}, 32'd0);
        end
        bus_mrdy = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 srdy", {31'b0, bus_srdy}, 32'd0);
        chk("R1 rdata", bus_rdata, 32'd0);
        chk("R1 out byte", {24'b0, out_dev_data}, 32'd0);
        chk("R1 avail", {31'b0, out_dev_avail}, 32'd0);
        rst_n = 1'b1;
        xfer(IN_A + 16'd4, 1'b0, 0, 0, 0, rd);  chk("R1 input status", rd, 32'd0);
        xfer(OUT_A + 16'd4, 1'b0, 0, 0, 0, rd); chk("R1 output status", rd, 32'd4);

        unselected(16'h0000);
        unselected(16'h0018);
        unselected(16'h0030);

        // R4 R5 sweep of every input byte
        for (int b = 0; b < 256; b++) begin
            strobe(b[7:0]);
            xfer(IN_A + 16'd4, 1'b0, 0, 0, 0, rd); chk("R4 status ready", rd, 32'd2);
            xfer(IN_A + 16'd1, 1'b0, 0, 0, 0, rd); chk("R4 input byte", rd, {24'b0, b[7:0]});
            xfer(IN_A + 16'd4, 1'b0, 0, 0, 0, rd); chk("R5 cleared by read", rd, 32'd0);
        end

        // R5 overwrite
        strobe(8'h11); strobe(8'h22);
        xfer(IN_A, 1'b0, 0, 0, 0, rd); chk("R5 overwrite", rd, 32'h22);

        // R5 strobe collides with data read
        strobe(8'h33);
        in_dev_data = 8'h44;
        xfer(IN_A, 1'b0, 0, 1, 0, rd); chk("R5 collision old byte", rd, 32'h33);
        xfer(IN_A + 16'd4, 1'b0, 0, 0, 0, rd); chk("R5 strobe wins flag", rd, 32'd2);
        xfer(IN_A, 1'b0, 0, 0, 0, rd); chk("R5 strobe wins byte", rd, 32'h44);

        // R8 ignored writes
        strobe(8'h55);
        xfer(IN_A, 1'b1, 32'hFFFF_FFFF, 0, 0, rd);
        xfer(IN_A + 16'd4, 1'b1, 32'hFFFF_FFFF, 0, 0, rd);
        xfer(IN_A + 16'd4, 1'b0, 0, 0, 0, rd); chk("R8 input flag kept", rd, 32'd2);
        xfer(IN_A, 1'b0, 0, 0, 0, rd); chk("R8 input byte kept", rd, 32'h55);
        xfer(OUT_A + 16'd4, 1'b1, 32'hFFFF_FFAB, 0, 0, rd);
        chk("R8 output byte kept", {24'b0, out_dev_data}, 32'd0);
        xfer(OUT_A + 16'd4, 1'b0, 0, 0, 0, rd); chk("R8 output flag kept", rd, 32'd4);

        // R6 R7 sweep of every output byte
        for (int b = 0; b < 256; b++) begin
            xfer(OUT_A, 1'b1, {24'hABCDEF, b[7:0]}, 0, 0, rd);
            chk("R6 out byte", {24'b0, out_dev_data}, {24'b0, b[7:0]});
            chk("R6 avail", {31'b0, out_dev_avail}, 32'd1);
            xfer(OUT_A + 16'd6, 1'b0, 0, 0, 0, rd); chk("R6 status busy", rd, 32'd0);
            xfer(OUT_A + 16'd2, 1'b0, 0, 0, 0, rd); chk("R6 read back", rd, {24'b0, b[7:0]});
            ack_pulse();
            xfer(OUT_A + 16'd4, 1'b0, 0, 0, 0, rd); chk("R7 ack sets free", rd, 32'd4);
        end

        // R7 ack while already free
        ack_pulse();
        xfer(OUT_A + 16'd4, 1'b0, 0, 0, 0, rd); chk("R7 ack when free", rd, 32'd4);
        // R7 ack collides with write
        xfer(OUT_A, 1'b1, 32'h5A, 0, 1, rd);
        xfer(OUT_A + 16'd4, 1'b0, 0, 0, 0, rd); chk("R7 write wins", rd, 32'd0);
        chk("R7 byte loaded", {24'b0, out_dev_data}, 32'h5A);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule